// File: doc/BRIEF.md
# Per-Cycle Warp Issue Scheduler

This block picks, on every clock, which resident warp of one execution sub-partition sends instructions down the pipe. Each resident warp shows the scheduler its next two decoded instructions. The scheduler judges each warp ready or stalled against a private table of destination registers whose long-latency results are still outstanding. It then chooses one ready warp and lets it issue one instruction, or two back to back. Switching warps from one cycle to the next hides load and arithmetic latency, because a warp waiting on a result costs no issue slots.

Warps are placed into free slots by an allocation mask. Several slots may be filled in the same cycle, as when a whole thread block lands. The oldest allocation wins the pick. Warps that were allocated together share a rotating tie-break. Results come back on a return port that names the warp and the register, and that clears the outstanding bit. A warp that has been marked finished stops issuing. It is reported once, and its slot freed, only when no result it is waiting on remains outstanding.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no slot is resident and no register is outstanding; `idle` is 1 and `issue_valid` and `drain_valid` are 0.
- R2: A warp can issue only if all of these hold: it is resident, it is not finished, its head instruction is valid, and neither the head's used sources nor its written destination are outstanding. Instruction descriptors are 17 bits: bit 0 valid, bit 1 load, bit 2 writes, bits 6:3 destination, bit 7 uses source A, bits 11:8 source A, bit 12 uses source B, bits 16:13 source B. `idle` is 1 exactly in the cycles in which no warp can issue.
- R3: Among warps that can issue, one from an earlier allocation cycle always wins over one allocated later, whatever their slot indices.
- R4: Among warps allocated in the same cycle, the winner is the first one found at or after a rotating pointer. The pointer resets to slot 0 and moves to the slot after each winner, so equal-age warps alternate.
- R5: The second instruction issues in the same cycle (`issue_dual` = 1) only if all of these hold: it is valid, the first instruction is not a load, it reads no outstanding register, and it neither reads nor writes the first instruction's destination.
- R6: Every issued instruction that writes a register marks that register outstanding for its warp from the next cycle. Later instructions that do not touch it keep issuing. The first one that reads or writes it stalls, for as long as the result stays away.
- R7: A result return clears the named bit at the clock edge, and a warp stalled on it can issue in the next cycle.
- R8: A finish pulse marks a resident warp finished. The warp issues nothing more. `drain_valid` with `drain_warp` is raised, for one cycle, only once none of its registers are outstanding, and the slot is then free.
- R9: Allocation bits for slots that are already resident are ignored and leave their age unchanged. A freed slot may be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_mask | input | NUM_WARPS | Slots to allocate this cycle, all with the same age |
| fin_valid | input | 1 | Finish pulse for `fin_warp` |
| fin_warp | input | log2(NUM_WARPS) | Warp whose threads have all completed |
| head_a | input | NUM_WARPS*17 | Next instruction of each warp |
| head_b | input | NUM_WARPS*17 | Instruction after that, for each warp |
| ret_valid | input | 1 | Result return strobe |
| ret_warp | input | log2(NUM_WARPS) | Warp of the returning result |
| ret_reg | input | 4 | Destination register of the returning result |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | log2(NUM_WARPS) | Warp chosen |
| issue_dual | output | 1 | Second instruction issues as well |
| idle | output | 1 | No warp could issue |
| drain_valid | output | 1 | A finished warp has fully drained |
| drain_warp | output | log2(NUM_WARPS) | Warp that drained |

## Verification
Instruction pairs are varied so that dual issue is seen both allowed and blocked by a leading load, by a read-after-write on the first result, by a shared destination, and by an outstanding source. A load followed first by independent work and then by a dependent read shows that stalls happen per dependency and not per warp. Allocation in separate cycles with slot indices opposite to age separates age order from index order. Two warps allocated together, with a younger ready warp beside them, separate the rotating tie-break from both plain index order and age order. A warp finished with a load still outstanding shows that release waits for the result.

// File: rtl/wis_pkg.sv
// Shared types for the warp issue scheduler.
// Assumes a fixed register count per warp; the descriptor layout is the
// interface contract with the decode stage feeding the heads.
package wis_pkg;
    parameter int REGS = 16;
    localparam int REG_W = $clog2(REGS);

    // Decoded instruction view seen by the scheduler (bit 0 = vld).
    typedef struct packed {
        logic [REG_W-1:0] src_b;
        logic             use_b;
        logic [REG_W-1:0] src_a;
        logic             use_a;
        logic [REG_W-1:0] dst;
        logic             wr;
        logic             ld;
        logic             vld;
    } inst_t;

    localparam int INST_W = $bits(inst_t);

    // True when the instruction uses or writes register r.
    function automatic logic touches(inst_t i, logic [REG_W-1:0] r);
        return (i.use_a && i.src_a == r) || (i.use_b && i.src_b == r) ||
               (i.wr && i.dst == r);
    endfunction

    // True when any register the instruction uses or writes is outstanding.
    function automatic logic blocked(inst_t i, logic [REGS-1:0] pend);
        return (i.use_a && pend[i.src_a]) || (i.use_b && pend[i.src_b]) ||
               (i.wr && pend[i.dst]);
    endfunction
endpackage

// File: rtl/wis_scoreboard.sv
// Per-warp outstanding-result table, one bit per destination register.
// Assumes a set and a clear never target the same bit in one cycle
// (an instruction writing an outstanding register cannot issue); set wins.
module wis_scoreboard
    import wis_pkg::*;
#(
    parameter int N = 8,
    localparam int WID_W = $clog2(N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0][REGS-1:0]     set_vec,
    input  logic                       clr_valid,
    input  logic [WID_W-1:0]           clr_warp,
    input  logic [REG_W-1:0]           clr_reg,
    output logic [N-1:0][REGS-1:0]     pend
);
    logic [N-1:0][REGS-1:0] pend_nxt;

    // Apply the return clear, then the issue sets.
    always_comb begin
        pend_nxt = pend;
        if (clr_valid) begin
            pend_nxt[clr_warp][clr_reg] = 1'b0;
        end
        pend_nxt = pend_nxt | set_vec;
    end

    // Hold the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= pend_nxt;
        end
    end
endmodule

// File: rtl/wis_age_order.sv
// Relative age matrix: older[j][i] is 1 when slot j was allocated in an
// earlier cycle than slot i. Slots allocated together are mutually unordered.
// Assumes take only contains slots that are currently free.
module wis_age_order #(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          take,
    output logic [N-1:0][N-1:0]   older
);
    genvar gj, gi;
    generate
        for (gj = 0; gj < N; gj++) begin : g_row
            for (gi = 0; gi < N; gi++) begin : g_col
                // Re-rank one pair whenever either member is newly allocated.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        older[gj][gi] <= 1'b0;
                    end else if (take[gj]) begin
                        older[gj][gi] <= 1'b0;
                    end else if (take[gi]) begin
                        older[gj][gi] <= 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wis_pick.sv
// Winner selection: the oldest ready warps form a tied set, and a rotating
// pointer chooses among them. Assumes N is a power of two.
module wis_pick #(
    parameter int N = 8,
    localparam int WID_W = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          elig,
    input  logic [N-1:0][N-1:0]   older,
    output logic                  any,
    output logic [WID_W-1:0]      win
);
    logic [N-1:0]     top;
    logic [WID_W-1:0] ptr;

    // A ready warp is in the top set when no ready warp is older.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < N; j++) begin
                beaten = beaten | (elig[j] & older[j][i]);
            end
            top[i] = elig[i] & ~beaten;
        end
    end

    // Scan the top set from the pointer, wrapping.
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = 0; k < N; k++) begin
            logic [WID_W-1:0] idx;
            idx = ptr + WID_W'(k);
            if (!any && top[idx]) begin
                any = 1'b1;
                win = idx;
            end
        end
    end

    // Move the pointer past each winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (any) begin
            ptr <= win + WID_W'(1);
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
// Per-cycle warp issue scheduler for one sub-partition.
// Judges each resident warp ready or stalled against its scoreboard, picks
// the oldest ready warp (rotating among equals), allows a conditional second
// instruction, and frees finished warps once their results have returned.
// Assumes the decode stage advances a warp's heads after each issue.
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    localparam int WID_W = $clog2(NUM_WARPS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WARPS-1:0]          alloc_mask,
    input  logic                          fin_valid,
    input  logic [WID_W-1:0]              fin_warp,
    input  logic [NUM_WARPS*INST_W-1:0]   head_a,
    input  logic [NUM_WARPS*INST_W-1:0]   head_b,
    input  logic                          ret_valid,
    input  logic [WID_W-1:0]              ret_warp,
    input  logic [REG_W-1:0]              ret_reg,
    output logic                          issue_valid,
    output logic [WID_W-1:0]              issue_warp,
    output logic                          issue_dual,
    output logic                          idle,
    output logic                          drain_valid,
    output logic [WID_W-1:0]              drain_warp
);
    localparam int N = NUM_WARPS;

    inst_t                  ha [N];
    inst_t                  hb [N];
    logic [N-1:0]           active_q;
    logic [N-1:0]           done_q;
    logic [N-1:0]           take;
    logic [N-1:0]           elig;
    logic [N-1:0]           pair_ok;
    logic [N-1:0]           drain_bit;
    logic [N-1:0][N-1:0]    older;
    logic [N-1:0][REGS-1:0] pend;
    logic [N-1:0][REGS-1:0] set_vec;
    logic [N*REGS-1:0]      pend_flat;
    logic                   any;
    logic [WID_W-1:0]       win;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_warp
            // Slice the heads and judge this warp.
            always_comb begin
                ha[g] = inst_t'(head_a[g*INST_W +: INST_W]);
                hb[g] = inst_t'(head_b[g*INST_W +: INST_W]);
                elig[g] = active_q[g] & ~done_q[g] & ha[g].vld &
                          ~blocked(ha[g], pend[g]);
                pair_ok[g] = hb[g].vld & ~ha[g].ld & ~blocked(hb[g], pend[g]) &
                             ~(ha[g].wr & touches(hb[g], ha[g].dst));
            end
            assign pend_flat[g*REGS +: REGS] = pend[g];
        end
    endgenerate

    assign take = alloc_mask & ~active_q;

    wis_age_order #(.N(N)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .older (older)
    );

    wis_pick #(.N(N)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .older (older),
        .any   (any),
        .win   (win)
    );

    // Drive the issue outputs from the pick.
    always_comb begin
        issue_valid = any;
        issue_warp  = win;
        issue_dual  = any & pair_ok[win];
        idle        = ~any;
    end

    // Mark destinations of issued writing instructions.
    always_comb begin
        set_vec = '0;
        if (any && ha[win].wr) begin
            set_vec[win][ha[win].dst] = 1'b1;
        end
        if (any && pair_ok[win] && hb[win].wr) begin
            set_vec[win][hb[win].dst] = 1'b1;
        end
    end

    wis_scoreboard #(.N(N)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_valid (ret_valid),
        .clr_warp  (ret_warp),
        .clr_reg   (ret_reg),
        .pend      (pend)
    );

    // Report the lowest finished warp with nothing outstanding.
    always_comb begin
        drain_valid = 1'b0;
        drain_warp  = '0;
        drain_bit   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (active_q[i] && done_q[i] && pend[i] == '0) begin
                drain_valid = 1'b1;
                drain_warp  = WID_W'(i);
            end
        end
        if (drain_valid) begin
            drain_bit[drain_warp] = 1'b1;
        end
    end

    // Track residency and the finished flag per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            done_q   <= '0;
        end else begin
            active_q <= (active_q | take) & ~drain_bit;
            for (int i = 0; i < N; i++) begin
                if (take[i]) begin
                    done_q[i] <= 1'b0;
                end else if (fin_valid && fin_warp == WID_W'(i) && active_q[i]) begin
                    done_q[i] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched_chk.sv
// Property checker for the warp issue scheduler, attached by bind.
// Assumes the same parameters as the scheduler instance it watches.
module warp_issue_sched_chk
    import wis_pkg::*;
#(
    parameter int N = 8,
    localparam int WID_W = $clog2(N)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 issue_valid,
    input logic [WID_W-1:0]     issue_warp,
    input logic                 issue_dual,
    input logic                 drain_valid,
    input logic [WID_W-1:0]     drain_warp,
    input logic                 ret_valid,
    input logic [N*INST_W-1:0]  head_a,
    input logic [N-1:0]         active,
    input logic [N-1:0]         done,
    input logic [N*REGS-1:0]    pend
);
    inst_t             sel;
    logic [REGS-1:0]   drain_row;

    // View of the issued head and the draining warp's table row.
    always_comb begin
        sel       = inst_t'(head_a[issue_warp*INST_W +: INST_W]);
        drain_row = pend[drain_warp*REGS +: REGS];
    end

    // R2: only a resident, unfinished warp is ever chosen.
    a_r2_issue_resident: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (active[issue_warp] && !done[issue_warp]));

    // R5: no second instruction behind a load.
    a_r5_no_dual_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_dual) |-> !sel.ld);

    // R6: an issued write leaves its register outstanding.
    a_r6_dst_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && sel.wr && !ret_valid) |=>
            pend[$past(issue_warp)*REGS + int'($past(sel.dst))]);

    // R8: drain is reported only with an empty table row.
    a_r8_drain_clean: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> (drain_row == '0));

    // R8: a drained slot is no longer resident afterwards.
    a_r8_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |=> !active[$past(drain_warp)]);
endmodule

bind warp_issue_sched warp_issue_sched_chk #(.N(NUM_WARPS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_warp  (issue_warp),
    .issue_dual  (issue_dual),
    .drain_valid (drain_valid),
    .drain_warp  (drain_warp),
    .ret_valid   (ret_valid),
    .head_a      (head_a),
    .active      (active_q),
    .done        (done_q),
    .pend        (pend_flat)
);

// File: tb/tb_warp_issue_sched.sv
// Directed bench: one task per scenario, each checks its own results.
module tb_warp_issue_sched;
    import wis_pkg::*;
    localparam int N = 8;
    localparam int WID_W = $clog2(N);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N-1:0]           alloc_mask;
    logic                   fin_valid;
    logic [WID_W-1:0]       fin_warp;
    logic [N*INST_W-1:0]    head_a;
    logic [N*INST_W-1:0]    head_b;
    logic                   ret_valid;
    logic [WID_W-1:0]       ret_warp;
    logic [REG_W-1:0]       ret_reg;
    logic                   issue_valid;
    logic [WID_W-1:0]       issue_warp;
    logic                   issue_dual;
    logic                   idle;
    logic                   drain_valid;
    logic [WID_W-1:0]       drain_warp;

    logic [INST_W-1:0] ha [N];
    logic [INST_W-1:0] hb [N];
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            head_a[i*INST_W +: INST_W] = ha[i];
            head_b[i*INST_W +: INST_W] = hb[i];
        end
    end

    warp_issue_sched #(.NUM_WARPS(N)) dut (
        .clk(clk), .rst_n(rst_n), .alloc_mask(alloc_mask),
        .fin_valid(fin_valid), .fin_warp(fin_warp),
        .head_a(head_a), .head_b(head_b),
        .ret_valid(ret_valid), .ret_warp(ret_warp), .ret_reg(ret_reg),
        .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_dual(issue_dual), .idle(idle),
        .drain_valid(drain_valid), .drain_warp(drain_warp)
    );

    // Build a descriptor per the R2 layout.
    function automatic logic [INST_W-1:0] mk(bit v, bit ld, bit wr, int dst,
                                             bit ua, int sa, bit ub, int sb);
        logic [INST_W-1:0] d;
        d = '0;
        d[0] = v; d[1] = ld; d[2] = wr; d[6:3] = 4'(dst);
        d[7] = ua; d[11:8] = 4'(sa); d[12] = ub; d[16:13] = 4'(sb);
        return d;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        alloc_mask = '0; fin_valid = 1'b0; fin_warp = '0;
        ret_valid = 1'b0; ret_warp = '0; ret_reg = '0;
        for (int i = 0; i < N; i++) begin ha[i] = '0; hb[i] = '0; end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 idle", int'(idle), 1);
        chk("R1 issue_valid", int'(issue_valid), 0);
        chk("R1 drain_valid", int'(drain_valid), 0);
    endtask

    task automatic t_single();
        do_reset();
        ha[0] = mk(1, 0, 1, 1, 1, 2, 1, 3);
        hb[0] = mk(1, 0, 1, 4, 1, 5, 0, 0);
        alloc_mask = 8'h01;
        #1 chk("R2 not resident yet", int'(issue_valid), 0);
        nxt(); alloc_mask = '0;
        #1 chk("R2 issue", int'(issue_valid), 1);
        chk("R2 warp", int'(issue_warp), 0);
        chk("R5 dual independent", int'(issue_dual), 1);
        nxt(); ha[0] = mk(1, 0, 0, 0, 1, 1, 0, 0); hb[0] = '0;
        #1 chk("R2 blocked idle", int'(idle), 1);
        ret_valid = 1'b1; ret_warp = 0; ret_reg = 1;
        nxt(); ret_valid = 1'b0;
        #1 chk("R7 reissue", int'(issue_valid), 1);
        chk("R5 no second", int'(issue_dual), 0);
    endtask

    task automatic t_dual_block();
        do_reset();
        ha[0] = mk(1, 1, 1, 2, 0, 0, 0, 0); hb[0] = mk(1, 0, 1, 5, 1, 6, 0, 0);
        alloc_mask = 8'h01; nxt(); alloc_mask = '0;
        #1 chk("R5 load first valid", int'(issue_valid), 1);
        chk("R5 load first no dual", int'(issue_dual), 0);
        do_reset();
        ha[0] = mk(1, 0, 1, 2, 0, 0, 0, 0); hb[0] = mk(1, 0, 1, 5, 1, 2, 0, 0);
        alloc_mask = 8'h01; nxt(); alloc_mask = '0;
        #1 chk("R5 raw no dual", int'(issue_dual), 0);
        do_reset();
        ha[0] = mk(1, 0, 1, 2, 0, 0, 0, 0); hb[0] = mk(1, 0, 1, 2, 1, 9, 0, 0);
        alloc_mask = 8'h01; nxt(); alloc_mask = '0;
        #1 chk("R5 same dst no dual", int'(issue_dual), 0);
    endtask

    task automatic t_load();
        do_reset();
        ha[0] = mk(1, 1, 1, 3, 0, 0, 0, 0); hb[0] = mk(1, 0, 1, 9, 1, 3, 0, 0);
        alloc_mask = 8'h01; nxt(); alloc_mask = '0;
        #1 chk("R6 load issues", int'(issue_valid), 1);
        nxt(); ha[0] = mk(1, 0, 1, 5, 1, 6, 0, 0); hb[0] = mk(1, 0, 0, 0, 1, 3, 0, 0);
        #1 chk("R6 independent continues", int'(issue_valid), 1);
        chk("R6 dependent second held", int'(issue_dual), 0);
        nxt(); ha[0] = mk(1, 0, 0, 0, 1, 3, 0, 0); hb[0] = '0;
        #1 chk("R6 dependent stalls", int'(idle), 1);
        nxt();
        #1 chk("R6 still stalled", int'(idle), 1);
        ret_valid = 1'b1; ret_warp = 0; ret_reg = 3;
        nxt(); ret_valid = 1'b0;
        #1 chk("R7 released after return", int'(issue_valid), 1);
        do_reset();
        ha[0] = mk(1, 1, 1, 3, 0, 0, 0, 0);
        alloc_mask = 8'h01; nxt(); alloc_mask = '0;
        nxt(); ha[0] = mk(1, 0, 1, 3, 0, 0, 0, 0);
        #1 chk("R2 write-after-write stall", int'(idle), 1);
    endtask

    task automatic t_age();
        do_reset();
        alloc_mask = 8'h40; nxt(); alloc_mask = 8'h02; nxt(); alloc_mask = '0;
        ha[6] = mk(1, 0, 0, 0, 0, 0, 0, 0); ha[1] = mk(1, 0, 0, 0, 0, 0, 0, 0);
        #1 chk("R3 oldest wins", int'(issue_warp), 6);
        nxt(); alloc_mask = 8'h40;
        #1 chk("R3 oldest again", int'(issue_warp), 6);
        nxt(); alloc_mask = '0;
        #1 chk("R9 realloc ignored", int'(issue_warp), 6);
    endtask

    task automatic t_tie();
        do_reset();
        alloc_mask = 8'h0A; nxt(); alloc_mask = 8'h20;
        ha[1] = mk(1, 0, 0, 0, 0, 0, 0, 0); ha[3] = ha[1]; ha[5] = ha[1];
        #1 chk("R4 first tie pick", int'(issue_warp), 1);
        nxt(); alloc_mask = '0;
        #1 chk("R4 rotate", int'(issue_warp), 3);
        nxt();
        #1 chk("R4 wrap past younger", int'(issue_warp), 1);
        nxt();
        #1 chk("R4 rotate again", int'(issue_warp), 3);
    endtask

    task automatic t_drain();
        do_reset();
        ha[2] = mk(1, 1, 1, 7, 0, 0, 0, 0);
        alloc_mask = 8'h04; nxt(); alloc_mask = '0;
        #1 chk("R8 load issues", int'(issue_warp), 2);
        nxt(); ha[2] = '0; fin_valid = 1'b1; fin_warp = 2;
        #1 chk("R8 no early drain", int'(drain_valid), 0);
        nxt(); fin_valid = 1'b0; ha[2] = mk(1, 0, 0, 0, 0, 0, 0, 0);
        #1 chk("R8 finished no issue", int'(idle), 1);
        chk("R8 waits for result", int'(drain_valid), 0);
        ret_valid = 1'b1; ret_warp = 2; ret_reg = 7;
        nxt(); ret_valid = 1'b0;
        #1 chk("R8 drain raised", int'(drain_valid), 1);
        chk("R8 drain warp", int'(drain_warp), 2);
        nxt();
        #1 chk("R8 drain one cycle", int'(drain_valid), 0);
        chk("R8 slot freed", int'(idle), 1);
        alloc_mask = 8'h04; nxt(); alloc_mask = '0;
        #1 chk("R9 freed slot reused", int'(issue_valid), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_dual_block();
        t_load();
        t_age();
        t_tie();
        t_drain();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule